// File: doc/BRIEF.md
# Slave-Mode Audio ADC Clock and Reset Sequencer

This block runs on a single master clock and produces the two clocks that a delta-sigma audio converter needs in slave mode. The frame clock runs at the sample rate. The serial bit clock runs at a fixed multiple of it. Both are counted down synchronously from the master clock. The division is set by a speed-mode code, a ratio select, a bit-clock doubling select and a master-divide select. Each of these settings multiplies or divides the number of master clocks in one frame.

The block also controls the converter's active-low reset. That reset stays asserted until the synchronized power-good signal and the configuration have both been steady for a set number of master clocks. It is then released exactly on a frame boundary. After release, a data-valid flag stays low for a fixed number of whole frame periods while the converter's reference settles.

Some settings are illegal in slave mode. When one is selected, the block raises an error flag, keeps the converter in reset and holds both clocks low. Configuration is captured only while reset is asserted. Any change to it during operation, or any loss of power-good, pulls the converter back into reset and restarts the blanking interval.

Top module: `adc_clk_seq`

## Requirements
- R1: Single speed (speed code 2'b00): one frame lasts 256 master clocks with ratio_hi_i=0 and 512 with ratio_hi_i=1. It carries 64 bit-clock periods with bclk_x2_i=0 and 128 with bclk_x2_i=1.
- R2: Double speed (speed code 2'b01): one frame lasts 128 master clocks with ratio_hi_i=0 and 256 with ratio_hi_i=1, with 64 bit-clock periods. bclk_x2_i=1 is illegal in this mode.
- R3: Quad speed (speed code 2'b10) is legal only with ratio_hi_i=1 and bclk_x2_i=0, giving 128 master clocks and 64 bit clocks per frame. ratio_hi_i=0 (the 64x ratio) is illegal. Speed code 2'b11 is always illegal.
- R4: mdiv_i=1 doubles the number of master clocks per frame and per bit-clock period, compared with the same setting at mdiv_i=0.
- R5: The frame clock is high for exactly half of each frame. The bit clock is low in the cycle where the frame clock rises, so the two clocks stay phase-aligned.
- R6: With an illegal setting, cfg_err_o is high, conv_rst_no and data_valid_o are low, and both clocks stay low.
- R7: conv_rst_no rises only after pg_i, taken through a two-stage synchronizer, and the configuration have both been steady for PG_STABLE_CYC master clocks. The rise falls on the same edge where the frame clock falls.
- R8: When pg_i goes low during operation, conv_rst_no and data_valid_o are low by the third master-clock edge after the change.
- R9: Changing any configuration input while conv_rst_no is high drives conv_rst_no low on the next master-clock edge. After the next release, the full blanking interval runs again.
- R10: data_valid_o rises exactly BLANK_FRAMES frame periods after conv_rst_no rises, and it is low whenever conv_rst_no is low.
- R11: While rst_ni is low, frame_clk_o, bit_clk_o, conv_rst_no, data_valid_o and cfg_err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous block reset |
| pg_i | input | 1 | Supply power-good, asynchronous |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 reserved |
| ratio_hi_i | input | 1 | Selects the higher master-to-frame ratio of the mode |
| bclk_x2_i | input | 1 | Selects 128 bit clocks per frame (single speed only) |
| mdiv_i | input | 1 | Divides the master clock by two before the dividers |
| frame_clk_o | output | 1 | Frame (left/right) clock |
| bit_clk_o | output | 1 | Serial bit clock |
| conv_rst_no | output | 1 | Active-low converter reset |
| data_valid_o | output | 1 | Converter output usable |
| cfg_err_o | output | 1 | Illegal ratio setting selected |

## Verification
The bench measures the frame period, the high time and the bit-clock count in every legal setting. A wrong ratio decode or a missing prescaler therefore shows up as a period that is off by a factor of two. It drives the illegal settings, including the 64x quad ratio, and a design that decodes them loosely would release reset or toggle the clocks. It times reset release against the power-good rise and the frame-clock fall, and it times data-valid against release. An early release, a release off the frame boundary, or a blanking counter that counts a partial frame would each shift those counts. Dropping power-good and changing the configuration while running catches a design that ignores either event or fails to restart blanking.

// File: rtl/adc_clk_seq_pkg.sv
package adc_clk_seq_pkg;
  localparam int FSH_MAX = 9;              // log2 of largest ticks per frame
  localparam int SH_W    = $clog2(FSH_MAX + 1);

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    speed_e speed;
    logic   ratio_hi;
    logic   bclk_x2;
    logic   mdiv;
  } cfg_t;
endpackage

// File: rtl/adc_ratio_decode.sv
module adc_ratio_decode
  import adc_clk_seq_pkg::*;
(
  input  cfg_t            cfg_i,
  output logic            legal_o,
  output logic [SH_W-1:0] fsh_o,
  output logic [SH_W-1:0] bsh_o
);
  logic            ok;
  logic [SH_W-1:0] fsh;

  always_comb begin
    ok  = 1'b1;
    fsh = SH_W'(8);
    unique case (cfg_i.speed)
      SPD_SINGLE: fsh = cfg_i.ratio_hi ? SH_W'(9) : SH_W'(8);
      SPD_DOUBLE: begin
        fsh = cfg_i.ratio_hi ? SH_W'(8) : SH_W'(7);
        ok  = !cfg_i.bclk_x2;
      end
      SPD_QUAD: begin
        fsh = SH_W'(7);
        ok  = cfg_i.ratio_hi && !cfg_i.bclk_x2; // 64x slave ratio not allowed
      end
      default: ok = 1'b0;
    endcase
  end

  assign legal_o = ok;
  assign fsh_o   = ok ? fsh : SH_W'(8);
  assign bsh_o   = !ok ? SH_W'(2) :
                   (cfg_i.bclk_x2 ? fsh - SH_W'(7) : fsh - SH_W'(6));
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_clk_seq_pkg::*;
#(
  parameter int CNT_W = FSH_MAX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clear_i,
  input  logic            mdiv_i,
  input  logic [SH_W-1:0] fsh_i,
  input  logic [SH_W-1:0] bsh_i,
  output logic            frame_clk_o,
  output logic            bit_clk_o,
  output logic            wrap_o
);
  logic [CNT_W-1:0] cnt_q, fmask;
  logic             pre_q, tick, at_end;

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign fmask[i] = (32'(fsh_i) > i);
  end

  assign tick   = en_i && (!mdiv_i || pre_q);
  assign at_end = (cnt_q == fmask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= 1'b0;
    end else if (clear_i || !en_i) begin
      cnt_q <= '0;
      pre_q <= 1'b0;
    end else begin
      pre_q <= mdiv_i ? ~pre_q : 1'b0;
      if (tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign wrap_o      = tick && at_end && !clear_i;
  assign frame_clk_o = en_i && cnt_q[fsh_i - SH_W'(1)];
  assign bit_clk_o   = en_i && cnt_q[bsh_i - SH_W'(1)];
endmodule

// File: rtl/adc_rst_seq.sv
module adc_rst_seq #(
  parameter int STABLE_CYC   = 4096,
  parameter int BLANK_FRAMES = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_i,
  input  logic legal_i,
  input  logic cfg_same_i,
  input  logic wrap_i,
  output logic run_o,
  output logic valid_o
);
  localparam int ST_W = $clog2(STABLE_CYC + 1);
  localparam int BL_W = $clog2(BLANK_FRAMES + 1);

  logic            pg_s1, pg_s2, run_q, keep, stab_done, blank_done;
  logic [ST_W-1:0] stab_q;
  logic [BL_W-1:0] blank_q;

  assign keep       = pg_s2 && cfg_same_i;
  assign stab_done  = (stab_q == ST_W'(STABLE_CYC));
  assign blank_done = (blank_q == BL_W'(BLANK_FRAMES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_s1   <= 1'b0;
      pg_s2   <= 1'b0;
      run_q   <= 1'b0;
      stab_q  <= '0;
      blank_q <= '0;
    end else begin
      pg_s1 <= pg_i;
      pg_s2 <= pg_s1;
      if (!keep)           stab_q <= '0;
      else if (!stab_done) stab_q <= stab_q + 1'b1;
      // release only on a frame boundary
      if (run_q) run_q <= keep;
      else       run_q <= keep && legal_i && stab_done && wrap_i;
      if (!run_q || !keep)          blank_q <= '0;
      else if (wrap_i && !blank_done) blank_q <= blank_q + 1'b1;
    end
  end

  assign run_o   = run_q;
  assign valid_o = run_q && blank_done;
endmodule

// File: rtl/adc_clk_seq.sv
module adc_clk_seq
  import adc_clk_seq_pkg::*;
#(
  parameter int PG_STABLE_CYC = 4096,
  parameter int BLANK_FRAMES  = 2500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pg_i,
  input  logic [1:0] speed_i,
  input  logic       ratio_hi_i,
  input  logic       bclk_x2_i,
  input  logic       mdiv_i,
  output logic       frame_clk_o,
  output logic       bit_clk_o,
  output logic       conv_rst_no,
  output logic       data_valid_o,
  output logic       cfg_err_o
);
  cfg_t            cfg_in, cfg_q;
  logic            legal, cfg_same, wrap, run;
  logic [SH_W-1:0] fsh, bsh;

  assign cfg_in = cfg_t'({speed_i, ratio_hi_i, bclk_x2_i, mdiv_i});

  // configuration is only captured while the converter is held in reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_q <= '0;
    else if (!run) cfg_q <= cfg_in;
  end

  assign cfg_same = (cfg_in == cfg_q);

  adc_ratio_decode u_dec (
    .cfg_i   (cfg_q),
    .legal_o (legal),
    .fsh_o   (fsh),
    .bsh_o   (bsh)
  );

  adc_clk_div #(.CNT_W(FSH_MAX)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (legal),
    .clear_i     (!cfg_same),
    .mdiv_i      (cfg_q.mdiv),
    .fsh_i       (fsh),
    .bsh_i       (bsh),
    .frame_clk_o (frame_clk_o),
    .bit_clk_o   (bit_clk_o),
    .wrap_o      (wrap)
  );

  adc_rst_seq #(
    .STABLE_CYC   (PG_STABLE_CYC),
    .BLANK_FRAMES (BLANK_FRAMES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pg_i       (pg_i),
    .legal_i    (legal),
    .cfg_same_i (cfg_same),
    .wrap_i     (wrap),
    .run_o      (run),
    .valid_o    (data_valid_o)
  );

  assign conv_rst_no = run;
  assign cfg_err_o   = !legal;
endmodule

// File: rtl/adc_clk_seq_chk.sv
module adc_clk_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pg_i,
  input logic [1:0] speed_i,
  input logic       ratio_hi_i,
  input logic       bclk_x2_i,
  input logic       mdiv_i,
  input logic       frame_clk_o,
  input logic       bit_clk_o,
  input logic       conv_rst_no,
  input logic       data_valid_o,
  input logic       cfg_err_o
);
  AST_BCLK_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_clk_o) |-> !bit_clk_o); // R5
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (!conv_rst_no && !data_valid_o && !frame_clk_o && !bit_clk_o)); // R6
  AST_REL_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_rst_no) |-> !frame_clk_o); // R7
  AST_PG_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_i && !$past(pg_i) && !$past(pg_i, 2)) |=> !conv_rst_no); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_rst_no && !$stable({speed_i, ratio_hi_i, bclk_x2_i, mdiv_i})) |=> !conv_rst_no); // R9
  AST_VALID_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> conv_rst_no); // R10
  AST_BLANK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_rst_no) |-> !data_valid_o); // R10
endmodule

bind adc_clk_seq adc_clk_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pg_i         (pg_i),
  .speed_i      (speed_i),
  .ratio_hi_i   (ratio_hi_i),
  .bclk_x2_i    (bclk_x2_i),
  .mdiv_i       (mdiv_i),
  .frame_clk_o  (frame_clk_o),
  .bit_clk_o    (bit_clk_o),
  .conv_rst_no  (conv_rst_no),
  .data_valid_o (data_valid_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/sim_adc_clk_seq.sv
`timescale 1ns/1ps
module sim_adc_clk_seq;
  localparam int STABLE = 8;
  localparam int BLANK  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pg = 1'b0;
  logic [1:0] spd = 2'b00;
  logic       rh = 1'b0, bx = 1'b0, md = 1'b0;
  logic       fclk, bclk, crst_n, dval, cerr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_clk_seq #(.PG_STABLE_CYC(STABLE), .BLANK_FRAMES(BLANK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pg_i(pg), .speed_i(spd),
    .ratio_hi_i(rh), .bclk_x2_i(bx), .mdiv_i(md),
    .frame_clk_o(fclk), .bit_clk_o(bclk), .conv_rst_no(crst_n),
    .data_valid_o(dval), .cfg_err_o(cerr)
  );

  typedef struct packed {
    logic [1:0]  spd;
    logic        rh;
    logic        bx;
    logic        md;
    logic        err;
    logic [11:0] per;
    logic [8:0]  bits;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 12'd256,  9'd64},
    '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 12'd512,  9'd64},
    '{2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 12'd256,  9'd128},
    '{2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 12'd1024, 9'd128},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 12'd128,  9'd64},
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 12'd512,  9'd64},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 12'd128,  9'd64},
    '{2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 12'd256,  9'd64},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0,    9'd0},
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 12'd0,    9'd0},
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 12'd0,    9'd0},
    '{2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 12'd1024, 9'd64}
  };

  function automatic string tag_of(vec_t v);
    if (v.err) return v.spd[1] ? "R3 R6" : "R2 R6";
    if (v.md) return "R4";
    case (v.spd)
      2'b00:   return "R1";
      2'b01:   return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_release(output int cyc, output bit seen);
    cyc = 0;
    seen = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      cyc++;
      if (crst_n) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    for (int i = 0; i < 6000; i++) begin
      if (dval) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic measure(output int per, output int hi, output int bits,
                         output bit blo);
    logic pf, pb;
    pf = fclk;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!pf && fclk) break;
      pf = fclk;
    end
    blo = !bclk;
    pf = 1'b1;
    pb = bclk;
    per = 0; hi = 0; bits = 0;
    for (int i = 0; i < 3000; i++) begin
      per++;
      hi += int'(fclk);
      @(negedge clk);
      if (!pf && fclk) break;
      pf = fclk;
      if (!pb && bclk) bits++;
      pb = bclk;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int  cyc, per, hi, bits, any;
    bit  seen, blo;
    logic pf;

    // R11: reset state
    repeat (5) @(negedge clk);
    chk({fclk, bclk, crst_n, dval, cerr} == 5'b0, "R11", "outputs in reset",
        int'({fclk, bclk, crst_n, dval, cerr}), 0);
    rst_n = 1'b1;

    // R7: no release while power-good is low
    any = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      any += int'(crst_n);
    end
    chk(any == 0, "R7", "release without power-good", any, 0);

    // R7: stability window and frame-boundary release
    pg = 1'b1;
    cyc = 0;
    pf = fclk;
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cyc++;
      if (crst_n) begin seen = 1'b1; break; end
      pf = fclk;
    end
    chk(seen && cyc >= STABLE + 2, "R7", "cycles from power-good to release", cyc, STABLE + 2);
    chk(pf && !fclk, "R7", "release on frame clock fall", int'({pf, fclk}), 2);

    // R10: blanking interval
    wait_valid(cyc);
    chk(cyc == BLANK * 256, "R10", "cycles release to valid", cyc, BLANK * 256);

    // R9: config change during operation
    @(negedge clk);
    bx = 1'b1;
    @(negedge clk);
    chk(!crst_n && !dval, "R9", "reset after config change", int'({crst_n, dval}), 0);
    wait_release(cyc, seen);
    chk(seen && !dval, "R9", "re-release with valid low", int'({seen, dval}), 2);
    wait_valid(cyc);
    chk(cyc == BLANK * 256, "R9", "new blanking interval", cyc, BLANK * 256);

    // R8: power-good loss
    @(negedge clk);
    pg = 1'b0;
    repeat (3) @(negedge clk);
    chk(!crst_n && !dval, "R8", "reset after power-good loss", int'({crst_n, dval}), 0);
    any = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      any += int'(crst_n);
    end
    chk(any == 0, "R8", "held while power-good low", any, 0);
    pg = 1'b1;

    // vector table: R1..R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      spd = VT[v].spd; rh = VT[v].rh; bx = VT[v].bx; md = VT[v].md;
      if (VT[v].err) begin
        any = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 60; i++) begin
          @(negedge clk);
          any += int'(crst_n) + int'(dval) + int'(fclk) + int'(bclk) + int'(!cerr);
        end
        chk(any == 0, tag_of(VT[v]), "illegal setting not quiet", any, 0);
      end else begin
        measure(per, hi, bits, blo);
        chk(per == int'(VT[v].per), tag_of(VT[v]), "frame period", per, int'(VT[v].per));
        chk(bits == int'(VT[v].bits), tag_of(VT[v]), "bit clocks per frame", bits, int'(VT[v].bits));
        chk(hi * 2 == per, "R5", "frame high time", hi, per / 2);
        chk(blo, "R5", "bit clock low at frame rise", int'(!blo), 0);
        chk(!cerr, tag_of(VT[v]), "error flag on legal setting", int'(cerr), 0);
        wait_release(cyc, seen);
        chk(seen, tag_of(VT[v]), "release on legal setting", int'(seen), 1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule